// File: doc/BRIEF.md
# NAND Common-Space Access Timing Sequencer

This block times a single command, address or data cycle toward a NAND flash device or the common memory space of a PC Card socket. A 32-bit timing word holds four 8-bit cycle counts:

- setup time before the strobe,
- strobe width,
- hold time after the strobe,
- a data-bus turnaround delay that applies to writes.

The word is loaded through a simple load port. It is copied into a private snapshot when an access is accepted.

A start request comes with a read/write flag. The block then runs setup, strobe and hold phases in that order. During the strobe phase it drives the active-low write strobe (writes) or output strobe (reads). On writes it raises a data-drive enable once the turnaround delay has passed. It reports completion with a one-cycle done pulse. Some timing codes are reserved. When one of them governs the requested access, the block skips the access and answers with done and an error flag in the same cycle.

Top module: `nand_access_seq`

## Requirements
- R1: After reset the timing word is 0xFCFCFCFC and an access with no load uses it. Out of reset both strobes are high, the data-drive enable, busy, done and error are low, and both strobes stay high whenever busy is low.
- R2: The timing word is laid out as follows: bits 7:0 setup count S, bits 15:8 wait count W, bits 23:16 hold count H, bits 31:24 turnaround count Z. After a start is accepted, busy rises at the next clock edge and the strobe stays high for S+1 busy cycles.
- R3: The strobe is then low for W+1 cycles. It is the write strobe `we_n` when `wr` was 1 at start and the output strobe `oe_n` when `wr` was 0. The other strobe stays high.
- R4: After the strobe rises, busy stays high for exactly H more cycles (hold), with H from 1 to 254.
- R5: On a write, `data_oe` stays low for the first Z+1 busy cycles, counted from the first setup cycle. It is then high until busy falls. It is never high when Z+1 is at least the access length S+W+H+2. On a read, `data_oe` is never high.
- R6: A reserved code is a hold count of 0x00 or 0xFF, or a write with Z = 0xFF. When a start meets a reserved code, the block never raises busy or a strobe, and it pulses done and `cfg_err` together in the cycle after the start. A read with Z = 0xFF is valid and runs normally.
- R7: For a valid access, done is high for exactly one cycle, the cycle right after the last hold cycle, and `cfg_err` stays low.
- R8: A start while busy is ignored. A load during an access does not change that access, and it takes effect for the next access.
- R9: `we_n` and `oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load `cfg_word` into the timing word |
| cfg_word | input | 32 | New timing word |
| start | input | 1 | Access request, accepted only when idle |
| wr | input | 1 | 1 for write, 0 for read, sampled with start |
| we_n | output | 1 | Active-low write strobe |
| oe_n | output | 1 | Active-low output (read) strobe |
| data_oe | output | 1 | Data bus drive enable for writes |
| busy | output | 1 | Access in progress (setup, strobe or hold) |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Reserved timing code seen, access skipped |

## Verification
The bench measures each phase length, the index of the first driven data cycle and the position of the done pulse. Several off-by-one traps are covered: hold counted as H+1 like the other fields, turnaround counted from the strobe instead of from the access start, and drive enabled on reads. Each of these shifts a measured count by one or produces a drive where none is expected. Reserved codes are run for both directions, including a valid read with Z = 0xFF. A design that checks the turnaround code on reads would raise an error on that read. One test disturbs a running access with a second start and a new load. A design without the snapshot would stretch or restart that access.

// File: rtl/nand_access_seq.sv
module nand_access_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [31:0] cfg_word,
  input  logic        start,
  input  logic        wr,
  output logic        we_n,
  output logic        oe_n,
  output logic        data_oe,
  output logic        busy,
  output logic        done,
  output logic        cfg_err
);
  localparam logic [31:0] WORD_RST = 32'hFCFC_FCFC;
  localparam int EW = 10;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_FIN, S_FAULT} state_t;

  state_t        state;
  logic [31:0]   tword, snap;
  logic          snap_wr;
  logic [7:0]    cnt;
  logic [EW-1:0] elapsed;

  wire [7:0] new_hold = tword[23:16];
  wire [7:0] new_hiz  = tword[31:24];
  wire reserved = (new_hold == 8'h00) || (new_hold == 8'hFF) || (wr && new_hiz == 8'hFF);

  wire [7:0] c_setup = snap[7:0];
  wire [7:0] c_wait  = snap[15:8];
  wire [7:0] c_hold  = snap[23:16];
  wire [7:0] c_hiz   = snap[31:24];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tword <= WORD_RST;
    else if (cfg_load) tword <= cfg_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      snap    <= '0;
      snap_wr <= 1'b0;
      cnt     <= '0;
      elapsed <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (start) begin
            if (reserved) state <= S_FAULT;
            else begin
              state   <= S_SETUP;
              snap    <= tword;
              snap_wr <= wr;
              cnt     <= '0;
              elapsed <= '0;
            end
          end
        S_SETUP: begin
          elapsed <= elapsed + 1'b1;
          if (cnt == c_setup) begin
            state <= S_STROBE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_STROBE: begin
          elapsed <= elapsed + 1'b1;
          if (cnt == c_wait) begin
            state <= S_HOLD;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          elapsed <= elapsed + 1'b1;
          if (cnt == c_hold - 8'd1) state <= S_FIN;
          else cnt <= cnt + 1'b1;
        end
        S_FIN:   state <= S_IDLE;
        S_FAULT: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
  assign we_n    = !((state == S_STROBE) && snap_wr);
  assign oe_n    = !((state == S_STROBE) && !snap_wr);
  assign data_oe = busy && snap_wr && (elapsed > {2'b00, c_hiz});
  assign done    = (state == S_FIN) || (state == S_FAULT);
  assign cfg_err = (state == S_FAULT);
endmodule

module nand_access_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic we_n,
  input logic oe_n,
  input logic data_oe,
  input logic busy,
  input logic done,
  input logic cfg_err
);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !oe_n));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |-> done);
  // R5
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> !data_oe);
  // R1
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (we_n && oe_n && !data_oe));
  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
endmodule

bind nand_access_seq nand_access_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(we_n), .oe_n(oe_n), .data_oe(data_oe),
  .busy(busy), .done(done), .cfg_err(cfg_err)
);

// File: tb/test_nand_access_seq.sv
module test_nand_access_seq;
  logic clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, start = 1'b0, wr = 1'b0;
  logic [31:0] cfg_word = '0;
  logic we_n, oe_n, data_oe, busy, done, cfg_err;

  always #10 clk = ~clk;

  nand_access_seq i_nand_access_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .start(start), .wr(wr), .we_n(we_n), .oe_n(oe_n), .data_oe(data_oe),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int m_setup, m_we, m_oe, m_hold, m_drv_first, m_drv_cnt, m_done_idx, m_done_n, m_err, m_done_after;

  // {wr, timing word}
  localparam logic [32:0] VEC [9] = '{
    {1'b1, 32'h0203_0100}, {1'b0, 32'h0201_0402}, {1'b1, 32'h0A01_0000},
    {1'b1, 32'h00FE_0205}, {1'b0, 32'hFF02_0000}, {1'b1, 32'h0101_FEFE},
    {1'b1, 32'hFF02_0000}, {1'b0, 32'h0000_0101}, {1'b1, 32'h00FF_0000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic load, input logic wrf, input bit disturb);
    int idx;
    bit seen_strobe, seen_done;
    if (load) begin
      @(negedge clk); cfg_load = 1'b1; cfg_word = w;
      @(negedge clk); cfg_load = 1'b0;
    end
    @(negedge clk); start = 1'b1; wr = wrf;
    @(negedge clk); start = 1'b0;
    m_setup = 0; m_we = 0; m_oe = 0; m_hold = 0; m_drv_first = -1; m_drv_cnt = 0;
    m_done_idx = -1; m_done_n = 0; m_err = 0;
    idx = 0; seen_strobe = 0; seen_done = 0;
    while (!seen_done && idx < 3000) begin
      if (busy) begin
        if (!we_n || !oe_n) begin
          seen_strobe = 1;
          if (!we_n) m_we++;
          if (!oe_n) m_oe++;
        end else if (!seen_strobe) m_setup++;
        else m_hold++;
        if (data_oe) begin
          if (m_drv_first < 0) m_drv_first = idx;
          m_drv_cnt++;
        end
      end
      if (done) begin
        seen_done = 1; m_done_idx = idx; m_done_n++;
        m_err = cfg_err;
      end
      if (disturb && idx == 1) begin
        start = 1'b1; wr = ~wrf; cfg_load = 1'b1; cfg_word = 32'h0005_0505;
      end
      if (disturb && idx == 2) begin
        start = 1'b0; cfg_load = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    m_done_after = done;
  endtask

  task automatic expect_access(input logic [31:0] w, input logic wrf, input string name);
    int s, wt, h, z, total, dfirst, dcnt;
    bit bad;
    s = w[7:0]; wt = w[15:8]; h = w[23:16]; z = w[31:24];
    bad = (h == 0) || (h == 255) || (wrf && z == 255);
    if (bad) begin
      chk({name, " R6 setup"}, m_setup, 0);
      chk({name, " R6 strobe"}, m_we + m_oe, 0);
      chk({name, " R6 done idx"}, m_done_idx, 0);
      chk({name, " R6 err"}, m_err, 1);
      chk({name, " R6 done after"}, m_done_after, 0);
    end else begin
      total = s + 1 + wt + 1 + h;
      if (wrf) begin
        dfirst = (z + 1 < total) ? z + 1 : -1;
        dcnt   = (z + 1 < total) ? total - (z + 1) : 0;
      end else begin
        dfirst = -1; dcnt = 0;
      end
      chk({name, " R2 setup"}, m_setup, s + 1);
      chk({name, " R3 we_n"}, m_we, wrf ? wt + 1 : 0);
      chk({name, " R3 oe_n"}, m_oe, wrf ? 0 : wt + 1);
      chk({name, " R4 hold"}, m_hold, h);
      chk({name, " R5 drive first"}, m_drv_first, dfirst);
      chk({name, " R5 drive count"}, m_drv_cnt, dcnt);
      chk({name, " R7 done idx"}, m_done_idx, total);
      chk({name, " R7 err"}, m_err, 0);
      chk({name, " R7 done after"}, m_done_after, 0);
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset we_n", we_n, 1);
    chk("R1 reset oe_n", oe_n, 1);
    chk("R1 reset data_oe", data_oe, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset err", cfg_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle busy", busy, 0);

    // R1: default word 0xFCFCFCFC
    run(32'h0, 1'b0, 1'b1, 1'b0);
    expect_access(32'hFCFC_FCFC, 1'b1, "R1 default");

    for (int i = 0; i < 9; i++) begin
      run(VEC[i][31:0], 1'b1, VEC[i][32], 1'b0);
      expect_access(VEC[i][31:0], VEC[i][32], $sformatf("vec%0d", i));
    end

    // R8: disturbed access keeps its snapshot, new word applies next time
    run(32'h0002_0202, 1'b1, 1'b1, 1'b1);
    expect_access(32'h0002_0202, 1'b1, "R8 disturbed");
    run(32'h0, 1'b0, 1'b1, 1'b0);
    expect_access(32'h0005_0505, 1'b1, "R8 next");

    // R6: valid read after a fault returns to normal operation
    run(32'h0000_0001, 1'b1, 1'b0, 1'b0);
    expect_access(32'h0000_0001, 1'b0, "R6 hold0 read");
    run(32'hFF01_0101, 1'b1, 1'b0, 1'b0);
    expect_access(32'hFF01_0101, 1'b0, "R6 read hiz FF");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule